// File: doc/BRIEF.md
# Stopwatch Snapshot Read Buffer

This block sits between a live three-digit BCD stopwatch count (thousandths, hundredths and tenths of a second) and a processor read port that returns one digit per access. A read of the lowest digit copies all three live digits into a buffer in the same cycle and starts a hold. Later reads of the other two digits are then served from that buffer, so a carry that ripples through the live count during the read sequence cannot mix digits from two different instants. A read of the top digit ends the sequence and releases the hold.

A lap strobe from outside also fills the buffer with the current count and holds it until the top digit is read. If a lap strobe arrives while a read sequence is still open, the buffer is overwritten at once and the earlier digits are no longer valid. The read of the top digit that follows then keeps the hold in place and raises a renewal flag, which tells software to start again from the lowest digit. Each read strobe updates the registered read data on the clock edge that samples it. The renewal flag changes only on top-digit reads.

Top module: `snap_hold_buffer`

## Requirements
- R1: After reset the read data and the renewal flag are 0, and no hold is active, so a middle-digit read returns the live middle digit.
- R2: A low-digit read with no hold active returns the live low digit, copies all three live digits into the buffer in the same cycle, and starts a hold.
- R3: While a hold is active, middle- and top-digit reads return the buffered digits, whatever the live digits have become. The read data changes only on a clock edge where a read strobe is sampled.
- R4: A top-digit read that completes a sequence with no overwrite releases the hold and returns a renewal flag of 0. Later middle and top reads return live digits.
- R5: A middle- or top-digit read with no hold active returns the live digit and does not fill the buffer.
- R6: A lap strobe copies the three live digits into the buffer and starts a hold that lasts until the next top-digit read.
- R7: A lap strobe during an open read sequence (after a low-digit read and before the top-digit read) overwrites the buffer. The next top-digit read returns the new top digit, sets the renewal flag to 1 and keeps the hold.
- R8: Every top-digit read updates the renewal flag. The flag is 1 only when an overwrite happened during the sequence, and reads of other digits leave it unchanged.
- R9: A low-digit read during a hold refreshes the buffer from the live count, unless lap data is still unread. In that case the read returns the buffered lap digit and the lap data is kept.
- R10: Strobes are prioritised low, then middle, then top. A lap strobe in the same cycle as a read takes effect before that read, so the read returns the newly captured digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_lo | input | DIGIT_W | Live thousandths digit |
| cnt_mid | input | DIGIT_W | Live hundredths digit |
| cnt_hi | input | DIGIT_W | Live tenths digit |
| rd_lo | input | 1 | Read strobe for the low digit |
| rd_mid | input | 1 | Read strobe for the middle digit |
| rd_hi | input | 1 | Read strobe for the top digit |
| lap_stb | input | 1 | Lap capture strobe |
| rd_data | output | DIGIT_W | Registered digit returned by the last read |
| renew_flag | output | 1 | Buffer-overwritten flag, updated on top-digit reads |

## Verification
Most internal faults show up at the next read of another digit. A hold bit that is stuck or cleared too early makes a middle or top read return the live value where the bench expects the buffered one, or the reverse, one cycle after the strobe. A lost overwrite marker or lap-pending marker only shows at the following top-digit read, through the flag, or at the next low-digit read, which then returns a refreshed digit instead of the lap digit. The bench therefore moves the live count between every pair of reads, so each read clearly tells buffered and live sources apart.

// File: rtl/snaptime_pkg.sv
package snaptime_pkg;
  localparam int NUM_DIG = 3;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_MID  = 2'd2,
    SEL_HI   = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/snap_capture_ctrl.sv
module snap_capture_ctrl
  import snaptime_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rd_lo,
  input  logic    rd_mid,
  input  logic    rd_hi,
  input  logic    lap_stb,
  output rd_sel_e sel,
  output logic    load_buf,
  output logic    src_live,
  output logic    renew_flag
);
  logic hold_q, pend_q, renew_q, seq_q, flag_q;
  logic hold_d, pend_d, renew_d, seq_d, flag_d;
  logic hold_eff, pend_eff, renew_eff;

  // priority: low, middle, top
  always_comb begin
    if (rd_lo)       sel = SEL_LO;
    else if (rd_mid) sel = SEL_MID;
    else if (rd_hi)  sel = SEL_HI;
    else             sel = SEL_NONE;
  end

  // a lap in the same cycle counts as arriving before the read
  always_comb begin
    hold_eff  = hold_q | lap_stb;
    pend_eff  = pend_q | lap_stb;
    renew_eff = renew_q | (lap_stb & seq_q);
    load_buf  = lap_stb | ((sel == SEL_LO) & ~(hold_q & pend_q));
    src_live  = lap_stb | ~hold_q | ((sel == SEL_LO) & ~pend_q);
  end

  always_comb begin
    hold_d  = hold_eff;
    pend_d  = pend_eff;
    renew_d = renew_eff;
    seq_d   = seq_q;
    flag_d  = flag_q;
    case (sel)
      SEL_LO: begin
        hold_d  = 1'b1;
        seq_d   = 1'b1;
        renew_d = 1'b0;
      end
      SEL_HI: begin
        flag_d = renew_eff;
        seq_d  = 1'b0;
        if (renew_eff) begin
          renew_d = 1'b0;
        end else begin
          hold_d = 1'b0;
          pend_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      pend_q  <= 1'b0;
      renew_q <= 1'b0;
      seq_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      pend_q  <= pend_d;
      renew_q <= renew_d;
      seq_q   <= seq_d;
      flag_q  <= flag_d;
    end
  end

  assign renew_flag = flag_q;

  // R2
  lo_starts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_LO) |=> hold_q);

  // R8
  flag_only_on_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_HI) |=> $stable(flag_q));

  // R7
  renew_keeps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_HI && renew_q) |=> (hold_q && flag_q));

  // R4
  hi_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_HI && !renew_q && !lap_stb && !seq_q) |=> (!hold_q && !flag_q));

  // R7
  renew_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    renew_q |-> hold_q);
endmodule

// File: rtl/snap_buffer.sv
module snap_buffer
  import snaptime_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [NUM_DIG-1:0][DIGIT_W-1:0] live,
  output logic [NUM_DIG-1:0][DIGIT_W-1:0] buf_q
);
  logic [NUM_DIG-1:0][DIGIT_W-1:0] buf_d;

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
    always_comb buf_d[g] = load ? live[g] : buf_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) buf_q[g] <= '0;
      else        buf_q[g] <= buf_d[g];
    end
  end

  // R3
  buf_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(buf_q));
endmodule

// File: rtl/snap_read_port.sv
module snap_read_port
  import snaptime_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  rd_sel_e                         sel,
  input  logic                            src_live,
  input  logic [NUM_DIG-1:0][DIGIT_W-1:0] live,
  input  logic [NUM_DIG-1:0][DIGIT_W-1:0] buf_q,
  output logic [DIGIT_W-1:0]              rd_data
);
  logic [NUM_DIG-1:0][DIGIT_W-1:0] src;
  logic [DIGIT_W-1:0]              pick, data_d, data_q;

  always_comb begin
    src = src_live ? live : buf_q;
    case (sel)
      SEL_MID: pick = src[1];
      SEL_HI:  pick = src[2];
      default: pick = src[0];
    endcase
    data_d = (sel != SEL_NONE) ? pick : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign rd_data = data_q;

  // R3
  data_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |=> $stable(data_q));
endmodule

// File: rtl/snap_hold_buffer.sv
module snap_hold_buffer
  import snaptime_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] cnt_lo,
  input  logic [DIGIT_W-1:0] cnt_mid,
  input  logic [DIGIT_W-1:0] cnt_hi,
  input  logic               rd_lo,
  input  logic               rd_mid,
  input  logic               rd_hi,
  input  logic               lap_stb,
  output logic [DIGIT_W-1:0] rd_data,
  output logic               renew_flag
);
  logic rst_meta, rst_sync;
  logic load_buf, src_live;
  rd_sel_e sel;
  logic [NUM_DIG-1:0][DIGIT_W-1:0] live, buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign live = {cnt_hi, cnt_mid, cnt_lo};

  snap_capture_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync),
    .rd_lo      (rd_lo),
    .rd_mid     (rd_mid),
    .rd_hi      (rd_hi),
    .lap_stb    (lap_stb),
    .sel        (sel),
    .load_buf   (load_buf),
    .src_live   (src_live),
    .renew_flag (renew_flag)
  );

  snap_buffer #(.DIGIT_W(DIGIT_W)) i_buf (
    .clk   (clk),
    .rst_n (rst_sync),
    .load  (load_buf),
    .live  (live),
    .buf_q (buf_q)
  );

  snap_read_port #(.DIGIT_W(DIGIT_W)) i_port (
    .clk      (clk),
    .rst_n    (rst_sync),
    .sel      (sel),
    .src_live (src_live),
    .live     (live),
    .buf_q    (buf_q),
    .rd_data  (rd_data)
  );
endmodule

// File: tb/test_snap_hold_buffer.sv
module test_snap_hold_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] cnt_lo = '0, cnt_mid = '0, cnt_hi = '0;
  logic rd_lo = 1'b0, rd_mid = 1'b0, rd_hi = 1'b0, lap_stb = 1'b0;
  logic [DW-1:0] rd_data;
  logic renew_flag;

  typedef struct {
    logic [DW-1:0] d;
    logic          f;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int issued = 0;
  int checked = 0;
  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snap_hold_buffer #(.DIGIT_W(DW)) i_snap_hold_buffer (
    .clk(clk), .rst_n(rst_n),
    .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .cnt_hi(cnt_hi),
    .rd_lo(rd_lo), .rd_mid(rd_mid), .rd_hi(rd_hi), .lap_stb(lap_stb),
    .rd_data(rd_data), .renew_flag(renew_flag)
  );

  always @(posedge clk) if (rd_lo | rd_mid | rd_hi) issued <= issued + 1;

  // monitor: compare each read result one half-cycle after its edge
  always @(negedge clk) begin
    if (checked < issued) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (rd_data !== e.d || renew_flag !== e.f) begin
        n_bad++;
        $display("FAIL %s: actual data=%0d flag=%0d, expected data=%0d flag=%0d",
                 e.tag, rd_data, renew_flag, e.d, e.f);
      end
      checked++;
    end
  end

  task automatic set_live(input logic [DW-1:0] h, input logic [DW-1:0] m,
                          input logic [DW-1:0] l);
    cnt_hi = h; cnt_mid = m; cnt_lo = l;
  endtask

  // which: 0 low, 1 middle, 2 top
  task automatic rd(input int which, input logic lap, input logic [DW-1:0] d,
                    input logic f, input string tag);
    exp_t e;
    @(negedge clk);
    e.d = d; e.f = f; e.tag = tag;
    exp_q.push_back(e);
    rd_lo = (which == 0); rd_mid = (which == 1); rd_hi = (which == 2);
    lap_stb = lap;
    @(negedge clk);
    rd_lo = 1'b0; rd_mid = 1'b0; rd_hi = 1'b0; lap_stb = 1'b0;
  endtask

  task automatic lap_only();
    @(negedge clk);
    lap_stb = 1'b1;
    @(negedge clk);
    lap_stb = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_cmp++;
    if (rd_data !== '0 || renew_flag !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: actual data=%0d flag=%0d, expected 0/0", rd_data, renew_flag);
    end
    set_live(1, 2, 3);
    rd(1, 0, 2, 0, "R1 no hold after reset");

    // R5 unheld reads are live and capture nothing
    set_live(4, 5, 6);
    rd(2, 0, 4, 0, "R5 unheld top");
    set_live(7, 8, 9);
    rd(1, 0, 8, 0, "R5 unheld middle");

    // R2 / R3 / R4 ordered sequence
    set_live(1, 2, 3);
    rd(0, 0, 3, 0, "R2 low capture");
    set_live(7, 8, 9);
    rd(1, 0, 2, 0, "R3 buffered middle");
    rd(2, 0, 1, 0, "R3 buffered top");
    rd(1, 0, 8, 0, "R4 released");

    // R9 refresh while holding
    set_live(1, 1, 1);
    rd(0, 0, 1, 0, "R9 first low");
    set_live(2, 2, 2);
    rd(0, 0, 2, 0, "R9 refreshed low");
    set_live(3, 3, 3);
    rd(1, 0, 2, 0, "R9 refreshed middle");
    rd(2, 0, 2, 0, "R9 refreshed top");

    // R6 lap capture
    set_live(4, 5, 6);
    lap_only();
    set_live(0, 0, 0);
    rd(1, 0, 5, 0, "R6 lap middle");
    rd(2, 0, 4, 0, "R6 lap top");
    rd(1, 0, 0, 0, "R6 released");

    // R9 pending lap survives a low read
    set_live(1, 2, 3);
    lap_only();
    set_live(7, 7, 7);
    rd(0, 0, 3, 0, "R9 lap low kept");
    rd(1, 0, 2, 0, "R9 lap middle");
    rd(2, 0, 1, 0, "R9 lap top");
    rd(0, 0, 7, 0, "R9 fresh low after lap");
    rd(2, 0, 7, 0, "R9 fresh top");

    // R7 / R8 overwrite during a sequence
    set_live(1, 2, 3);
    rd(0, 0, 3, 0, "R7 open sequence");
    set_live(4, 5, 6);
    lap_only();
    set_live(9, 9, 9);
    rd(1, 0, 5, 0, "R7 overwritten middle");
    rd(2, 0, 4, 1, "R7 flag set");
    rd(1, 0, 5, 1, "R7 hold kept, R8 flag unchanged");
    rd(0, 0, 6, 1, "R8 restart low");
    rd(1, 0, 5, 1, "R8 restart middle");
    rd(2, 0, 4, 0, "R8 flag cleared");
    rd(1, 0, 9, 0, "R8 released");

    // R10 lap coincident with a read
    set_live(3, 2, 1);
    rd(1, 1, 2, 0, "R10 lap with middle read");
    set_live(0, 0, 0);
    rd(2, 0, 3, 0, "R10 lap top");
    set_live(5, 6, 7);
    rd(1, 0, 6, 0, "R10 released");
    // R10 priority: low beats middle
    @(negedge clk);
    begin
      exp_t e;
      e.d = 7; e.f = 0; e.tag = "R10 low wins over middle";
      exp_q.push_back(e);
    end
    rd_lo = 1'b1; rd_mid = 1'b1;
    @(negedge clk);
    rd_lo = 1'b0; rd_mid = 1'b0;
    set_live(8, 8, 8);
    rd(1, 0, 6, 0, "R10 held after low");
    rd(2, 0, 5, 0, "R10 top closes");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule